// File: doc/BRIEF.md
# Adaptive Acoustic Feedback Canceller

This block sits between a microphone sample stream and a loudspeaker sample stream in a closed acoustic loop. It keeps a model of the path from loudspeaker to microphone as an adaptive FIR filter. The filter's input is the history of the samples this block itself sent to the loudspeaker. On every valid microphone sample, the filter's estimate of the leaked feedback is removed from the sample. The cleaned sample then goes through a forward path: a short equalizer followed by a programmable gain. The result of the forward path is the next loudspeaker sample, and that sample also enters the filter's delay line.

Because the filter's reference is produced inside the loop, removing the leaked component lets the forward gain be set higher than the point at which uncancelled feedback would start to howl. The filter adapts by sign-error LMS. The cleaned sample acts as the error, and the step size is a power of two. Every intermediate result clips to its word width instead of wrapping. A synchronous clear returns the loop to a silent, untrained state.

Top module: `feedback_canceller`

## Requirements
- R1: While `rst_ni` is low, `err_o`, `spk_o` and `valid_o` are 0. All coefficients, delay-line samples and equalizer history start at zero, so the first sample after reset gives `err_o` equal to `mic_i`.
- R2: For an accepted sample, the estimate is the sum over taps k of x[k]*w[k], shifted right arithmetically by 16 and clipped to 16 bits. `err_o` is mic_i minus the estimate, clipped to 16 bits. When the estimate is zero, `err_o` equals `mic_i`.
- R3: Every sum and product that reaches a 16-bit result clips to the range -32768..32767. No result wraps around.
- R4: The equalizer output is v = clip16((c0*e[n] + c1*e[n-1] + c2*e[n-2]) >>> 14). The terms e are the last three compensated samples. Coefficient cj is the signed 16-bit field `eq_coef_i[16*j+15:16*j]`, read as Q2.14.
- R5: `spk_o` = clip16((g*v) >>> 8), where g is `gain_i` read as unsigned Q4.8. With g = 0, `spk_o` is 0.
- R6: The loudspeaker sample produced for sample n becomes tap 0 of the delay line, which sample n+1 uses. Tap k holds the loudspeaker sample from k+1 accepted samples earlier. There are 16 taps.
- R7: After each accepted sample, every coefficient w[k] (18-bit signed, Q2.16) changes by +(x[k] >>> mu_i) if the compensated sample is positive. It changes by the negative of that amount if the compensated sample is negative, and stays the same if the sample is zero. The updated value clips to -131072..131071.
- R8: Outputs update on the clock edge that accepts `valid_i`, and `valid_o` is high for exactly the following cycle. Without an accepted sample, `err_o` and `spk_o` hold their values and `mic_i`, `gain_i`, `eq_coef_i` and `mu_i` have no effect.
- R9: `clear_i` acts synchronously and takes priority over `valid_i`. On the next edge it zeroes the coefficients, the delay line, the equalizer history, `err_o` and `spk_o`, and holds `valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of all loop state |
| valid_i | input | 1 | Microphone sample valid |
| mic_i | input | 16 | Microphone sample, signed |
| gain_i | input | 12 | Forward gain, unsigned Q4.8 |
| eq_coef_i | input | 48 | Three signed Q2.14 equalizer coefficients, tap 0 in the low bits |
| mu_i | input | 4 | Step size as a right-shift amount |
| err_o | output | 16 | Feedback-compensated sample |
| spk_o | output | 16 | Loudspeaker sample |
| valid_o | output | 1 | Outputs updated this cycle |

## Verification
The bench runs a bit-exact model of the loop next to the design. It feeds microphone input that contains a delayed, scaled copy of the design's own loudspeaker output, so the coefficients actually train. A one-sample slip in the delay line would make every later estimate wrong. So would a coefficient update that used the shifted-in sample, or one that moved on a zero error. Large inputs at a high gain and a zero step shift push the coefficients and outputs to their limits. A design that wrapped instead of clipping would flip the sign of the loudspeaker sample there. Clear is asserted together with a valid sample, and idle cycles carry changing inputs. These catch a design that lets the sample win over the clear, or one that updates its outputs when no sample is accepted.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam int ACC_W = 48;
  typedef logic signed [ACC_W-1:0] acc_t;

  function automatic logic above(acc_t v, int unsigned w);
    return v > ((acc_t'(1) <<< (w - 1)) - acc_t'(1));
  endfunction

  function automatic logic below(acc_t v, int unsigned w);
    return v < -(acc_t'(1) <<< (w - 1));
  endfunction
endpackage

// File: rtl/fbc_tap_bank.sv
module fbc_tap_bank import fbc_pkg::*; #(
  parameter int TAPS = 16,
  parameter int DW   = 16,
  parameter int CW   = 18,
  parameter int CF   = 16,
  parameter int MUW  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 step_i,
  input  logic signed [DW-1:0] spk_i,
  input  logic signed [DW-1:0] err_i,
  input  logic [MUW-1:0]       mu_i,
  output logic signed [DW-1:0] est_o
);
  localparam logic signed [CW-1:0] C_MAX = {1'b0, {(CW-1){1'b1}}};
  localparam logic signed [CW-1:0] C_MIN = {1'b1, {(CW-1){1'b0}}};
  localparam logic signed [DW-1:0] D_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] D_MIN = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW-1:0] x_q   [TAPS];
  logic signed [CW-1:0] w_q   [TAPS];
  logic signed [CW-1:0] w_nxt [TAPS];
  acc_t                 prod  [TAPS];
  logic                 err_pos, err_neg;
  acc_t                 sum_c, sum_sh;

  assign err_neg = err_i[DW-1];
  assign err_pos = !err_i[DW-1] && (err_i != '0);

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    acc_t xs, wsum;
    assign prod[k] = acc_t'(x_q[k]) * acc_t'(w_q[k]);
    assign xs      = acc_t'(x_q[k]) >>> mu_i;
    // sign-error LMS step on the pre-shift tap value
    assign wsum    = acc_t'(w_q[k]) + (err_pos ? xs : (err_neg ? -xs : '0));
    assign w_nxt[k] = above(wsum, CW) ? C_MAX :
                      below(wsum, CW) ? C_MIN : wsum[CW-1:0];
  end

  always_comb begin
    sum_c = '0;
    for (int k = 0; k < TAPS; k++) sum_c = sum_c + prod[k];
    sum_sh = sum_c >>> CF;
    est_o  = above(sum_sh, DW) ? D_MAX :
             below(sum_sh, DW) ? D_MIN : sum_sh[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < TAPS; k++) begin
        x_q[k] <= '0;
        w_q[k] <= '0;
      end
    end else if (clear_i) begin
      for (int k = 0; k < TAPS; k++) begin
        x_q[k] <= '0;
        w_q[k] <= '0;
      end
    end else if (step_i) begin
      for (int k = 0; k < TAPS; k++) w_q[k] <= w_nxt[k];
      x_q[0] <= spk_i;
      for (int k = 1; k < TAPS; k++) x_q[k] <= x_q[k-1];
    end
  end
endmodule

// File: rtl/fbc_fwd_path.sv
module fbc_fwd_path import fbc_pkg::*; #(
  parameter int DW      = 16,
  parameter int EQ_TAPS = 3,
  parameter int EW      = 16,
  parameter int EF      = 14,
  parameter int GW      = 12,
  parameter int GF      = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    step_i,
  input  logic signed [DW-1:0]    err_i,
  input  logic [EQ_TAPS*EW-1:0]   eq_coef_i,
  input  logic [GW-1:0]           gain_i,
  output logic signed [DW-1:0]    spk_o
);
  localparam int HL = EQ_TAPS - 1;
  localparam logic signed [DW-1:0] D_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] D_MIN = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW-1:0] hist_q [HL];
  acc_t                 term   [EQ_TAPS];
  acc_t                 eq_sum, eq_sh, g_prod, g_sh;
  logic signed [DW-1:0] eq_v;

  for (genvar j = 0; j < EQ_TAPS; j++) begin : g_eq
    logic signed [DW-1:0] s;
    if (j == 0) begin : g_cur
      assign s = err_i;
    end else begin : g_old
      assign s = hist_q[j-1];
    end
    assign term[j] = acc_t'(s) * acc_t'($signed(eq_coef_i[j*EW +: EW]));
  end

  always_comb begin
    eq_sum = '0;
    for (int j = 0; j < EQ_TAPS; j++) eq_sum = eq_sum + term[j];
    eq_sh  = eq_sum >>> EF;
    eq_v   = above(eq_sh, DW) ? D_MAX : below(eq_sh, DW) ? D_MIN : eq_sh[DW-1:0];
    g_prod = acc_t'(eq_v) * acc_t'({1'b0, gain_i});
    g_sh   = g_prod >>> GF;
    spk_o  = above(g_sh, DW) ? D_MAX : below(g_sh, DW) ? D_MIN : g_sh[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < HL; j++) hist_q[j] <= '0;
    end else if (clear_i) begin
      for (int j = 0; j < HL; j++) hist_q[j] <= '0;
    end else if (step_i) begin
      hist_q[0] <= err_i;
      for (int j = 1; j < HL; j++) hist_q[j] <= hist_q[j-1];
    end
  end
endmodule

// File: rtl/feedback_canceller.sv
module feedback_canceller import fbc_pkg::*; #(
  parameter int TAPS    = 16,
  parameter int DW      = 16,
  parameter int CW      = 18,
  parameter int CF      = 16,
  parameter int MUW     = 4,
  parameter int EQ_TAPS = 3,
  parameter int EW      = 16,
  parameter int EF      = 14,
  parameter int GW      = 12,
  parameter int GF      = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  valid_i,
  input  logic signed [DW-1:0]  mic_i,
  input  logic [GW-1:0]         gain_i,
  input  logic [EQ_TAPS*EW-1:0] eq_coef_i,
  input  logic [MUW-1:0]        mu_i,
  output logic signed [DW-1:0]  err_o,
  output logic signed [DW-1:0]  spk_o,
  output logic                  valid_o
);
  localparam logic signed [DW-1:0] D_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] D_MIN = {1'b1, {(DW-1){1'b0}}};

  logic                 step;
  logic signed [DW-1:0] est_w, err_w, spk_w;
  acc_t                 diff;

  assign step = valid_i && !clear_i;

  fbc_tap_bank #(.TAPS(TAPS), .DW(DW), .CW(CW), .CF(CF), .MUW(MUW)) u_taps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .step_i (step),
    .spk_i  (spk_w),
    .err_i  (err_w),
    .mu_i   (mu_i),
    .est_o  (est_w)
  );

  assign diff  = acc_t'(mic_i) - acc_t'(est_w);
  assign err_w = above(diff, DW) ? D_MAX : below(diff, DW) ? D_MIN : diff[DW-1:0];

  fbc_fwd_path #(.DW(DW), .EQ_TAPS(EQ_TAPS), .EW(EW), .EF(EF), .GW(GW), .GF(GF)) u_fwd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .step_i   (step),
    .err_i    (err_w),
    .eq_coef_i(eq_coef_i),
    .gain_i   (gain_i),
    .spk_o    (spk_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o   <= '0;
      spk_o   <= '0;
      valid_o <= 1'b0;
    end else if (clear_i) begin
      err_o   <= '0;
      spk_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        err_o <= err_w;
        spk_o <= spk_w;
      end
    end
  end
endmodule

// File: rtl/fbc_checker.sv
module fbc_checker #(
  parameter int DW = 16,
  parameter int GW = 12
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 clear_i,
  input logic                 valid_i,
  input logic signed [DW-1:0] mic_i,
  input logic [GW-1:0]        gain_i,
  input logic signed [DW-1:0] est_i,
  input logic signed [DW-1:0] err_o,
  input logic signed [DW-1:0] spk_o,
  input logic                 valid_o
);
  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clear_i) |=> valid_o);

  p_valid_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && !clear_i) |=> !valid_o);

  p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clear_i) |=> ($stable(err_o) && $stable(spk_o)));

  p_clear_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (err_o == '0 && spk_o == '0 && !valid_o));

  p_pass_through_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clear_i && est_i == '0) |=> (err_o == $past(mic_i)));

  p_mute_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clear_i && gain_i == '0) |=> (spk_o == '0));
endmodule

bind feedback_canceller fbc_checker #(.DW(DW), .GW(GW)) u_fbc_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clear_i(clear_i),
  .valid_i(valid_i),
  .mic_i  (mic_i),
  .gain_i (gain_i),
  .est_i  (est_w),
  .err_o  (err_o),
  .spk_o  (spk_o),
  .valid_o(valid_o)
);

// File: tb/feedback_canceller_bench.sv
`timescale 1ns/1ps
module feedback_canceller_bench;
  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               clear_i = 1'b0;
  logic               valid_i = 1'b0;
  logic signed [15:0] mic_i = '0;
  logic [11:0]        gain_i = '0;
  logic [47:0]        eq_coef_i = '0;
  logic [3:0]         mu_i = '0;
  logic signed [15:0] err_o, spk_o;
  logic               valid_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  feedback_canceller u_feedback_canceller (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .valid_i(valid_i),
    .mic_i(mic_i), .gain_i(gain_i), .eq_coef_i(eq_coef_i), .mu_i(mu_i),
    .err_o(err_o), .spk_o(spk_o), .valid_o(valid_o)
  );

  // loop model built from the requirements
  longint mx [16];
  longint mw [16];
  longint me1, me2;
  int unsigned lcg = 32'h1234_5678;

  function automatic longint sat(longint v, int w);
    longint hi = (longint'(1) <<< (w - 1)) - 1;
    longint lo = -(longint'(1) <<< (w - 1));
    return (v > hi) ? hi : (v < lo) ? lo : v;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 16; k++) begin mx[k] = 0; mw[k] = 0; end
    me1 = 0; me2 = 0;
  endtask

  task automatic model_step(input longint m, output longint e, output longint u);
    longint acc, est, v, c0, c1, c2, xs;
    acc = 0;
    for (int k = 0; k < 16; k++) acc += mx[k] * mw[k];
    est = sat(acc >>> 16, 16);
    e   = sat(m - est, 16);
    c0  = longint'($signed(eq_coef_i[15:0]));
    c1  = longint'($signed(eq_coef_i[31:16]));
    c2  = longint'($signed(eq_coef_i[47:32]));
    v   = sat((c0 * e + c1 * me1 + c2 * me2) >>> 14, 16);
    u   = sat((longint'(gain_i) * v) >>> 8, 16);
    for (int k = 0; k < 16; k++) begin
      xs = mx[k] >>> mu_i;
      if (e > 0) mw[k] += xs; else if (e < 0) mw[k] -= xs;
      mw[k] = sat(mw[k], 18);
    end
    for (int k = 15; k > 0; k--) mx[k] = mx[k-1];
    mx[0] = u;
    me2 = me1; me1 = e;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input longint m, input string req, output longint u_out);
    longint e, u;
    @(negedge clk);
    valid_i = 1'b1;
    mic_i   = 16'(m);
    @(negedge clk);
    valid_i = 1'b0;
    model_step(m, e, u);
    check(longint'(err_o) == e, req, "err_o", longint'(err_o), e);
    check(longint'(spk_o) == u, req, "spk_o", longint'(spk_o), u);
    check(valid_o == 1'b1, req, "valid_o", longint'(valid_o), 1);
    u_out = u;
  endtask

  function automatic longint noise(int amp);
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return longint'(int'(lcg[23:8]) % amp) - longint'(amp / 2);
  endfunction

  task automatic set_eq(input int c0, input int c1, input int c2);
    eq_coef_i = {16'(c2), 16'(c1), 16'(c0)};
  endtask

  task automatic t_reset();
    check(err_o == 0, "R1", "err_o in reset", longint'(err_o), 0);
    check(spk_o == 0, "R1", "spk_o in reset", longint'(spk_o), 0);
    check(valid_o == 0, "R1", "valid_o in reset", longint'(valid_o), 0);
  endtask

  task automatic t_pass_mute();
    longint u;
    gain_i = 12'd0; set_eq(16384, 0, 0); mu_i = 4'd3;
    send(1234, "R1", u);
    check(err_o == 16'sd1234, "R1", "first sample after reset", longint'(err_o), 1234);
    send(-32768, "R2", u);
    send(32767, "R2", u);
    check(spk_o == 0, "R5", "zero gain output", longint'(spk_o), 0);
    send(-5, "R2", u);
  endtask

  task automatic t_eq_gain();
    longint u;
    gain_i = 12'd256; set_eq(16384, -8192, 4096); mu_i = 4'd15;
    send(1000, "R4", u);
    send(0, "R4", u);
    send(0, "R4", u);
    gain_i = 12'd640; set_eq(-12000, 20000, 3000);
    for (int i = 0; i < 12; i++) send(noise(4000), "R5", u);
  endtask

  task automatic t_saturate();
    longint u;
    gain_i = 12'hFFF; set_eq(32767, 0, 0); mu_i = 4'd4;
    send(30000, "R3", u);
    check(spk_o == 16'sd32767, "R3", "positive clip", longint'(spk_o), 32767);
    send(-30000, "R3", u);
    for (int i = 0; i < 10; i++) send((i % 2 == 0) ? 32000 : -32000, "R3", u);
  endtask

  task automatic t_adapt();
    longint u1 = 0, u2 = 0, u, m;
    gain_i = 12'd384; set_eq(16384, 0, 0); mu_i = 4'd6;
    for (int i = 0; i < 200; i++) begin
      m = sat(noise(3000) + (u1 >>> 1) + (u2 >>> 2), 16);
      send(m, (i % 2 == 0) ? "R6" : "R7", u);
      u2 = u1; u1 = u;
    end
  endtask

  task automatic t_coef_limit();
    longint u;
    gain_i = 12'd256; set_eq(16384, 0, 0); mu_i = 4'd0;
    for (int i = 0; i < 40; i++) send((i % 3 == 0) ? -20000 : 20000, "R7", u);
  endtask

  task automatic t_hold();
    longint u, e0, s0;
    send(777, "R8", u);
    e0 = longint'(err_o); s0 = longint'(spk_o);
    for (int i = 0; i < 5; i++) begin
      mic_i = 16'(i * 1111 - 3000); gain_i = 12'(i * 300); mu_i = 4'(i);
      @(negedge clk);
      check(valid_o == 0, "R8", "valid_o idle", longint'(valid_o), 0);
      check(longint'(err_o) == e0, "R8", "err_o hold", longint'(err_o), e0);
      check(longint'(spk_o) == s0, "R8", "spk_o hold", longint'(spk_o), s0);
    end
    gain_i = 12'd256; mu_i = 4'd6;
    send(-321, "R8", u);
  endtask

  task automatic t_clear();
    longint u;
    @(negedge clk);
    clear_i = 1'b1; valid_i = 1'b1; mic_i = 16'sd5000;
    @(negedge clk);
    clear_i = 1'b0; valid_i = 1'b0;
    model_clear();
    check(err_o == 0, "R9", "err_o after clear", longint'(err_o), 0);
    check(spk_o == 0, "R9", "spk_o after clear", longint'(spk_o), 0);
    check(valid_o == 0, "R9", "valid_o after clear", longint'(valid_o), 0);
    gain_i = 12'd256; set_eq(16384, 8192, 0);
    send(1234, "R9", u);
    check(err_o == 16'sd1234, "R9", "untrained after clear", longint'(err_o), 1234);
    check(spk_o == 16'sd1234, "R9", "history cleared", longint'(spk_o), 1234);
    send(100, "R9", u);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_pass_mute();
    t_eq_gain();
    t_saturate();
    t_adapt();
    t_coef_limit();
    t_hold();
    t_clear();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule